// File: doc/BRIEF.md
# Shared Up/Down Event Counter

This block keeps one signed count that two independent event inputs act on. A rising edge on the up input adds one and a rising edge on the down input takes one away, so the value held is the number of "in" events minus the number of "out" events. Each input is edge-detected inside the block. An input that stays high for many cycles therefore counts only once.

A programmable preset drives a registered "done" flag, which is set while the count is at or above the preset. Sticky overflow and underflow flags record an attempt to step past either signed limit; in that case the count wraps to the opposite limit. A registered "empty" flag shows a zero count, and two mirror outputs report the sampled level of each event input. A clear input zeroes the count and flags, and a load input copies the preset into the count. Between those commands and event edges the count holds its value.

Top module: `evt_updown_counter`

## Requirements
- R1: A 0→1 change of `up_in`, seen between two consecutive clock edges, increments `acc` by one at the second edge; holding `up_in` high causes no further change.
- R2: A 0→1 change of `dn_in` decrements `acc` by one in the same way, and counting continues below zero into negative two's-complement values.
- R3: When an up edge and a down edge are detected at the same clock edge, they cancel and `acc` does not change.
- R4: An up step taken while `acc` = +32767 wraps `acc` to −32768 and sets `ovf`, which stays 1 until a clear.
- R5: A down step taken while `acc` = −32768 wraps `acc` to +32767 and sets `unf`, which stays 1 until a clear.
- R6: After each clock edge, `done` is 1 exactly when the new `acc` ≥ `preset` (signed compare, using the `preset` present at that edge), including while the count runs beyond the preset.
- R7: `empty` is a registered flag that is 1 exactly when `acc` is zero.
- R8: `clr` high at a clock edge sets `acc` to 0 and clears `ovf` and `unf`. It wins over `load` and over any event edge seen at that edge, and such an edge is discarded.
- R9: `load` high with `clr` low copies `preset` into `acc`. It wins over any event edge at that edge, which is discarded, and it leaves `ovf` and `unf` unchanged.
- R10: With no edge, no clear and no load, `acc` and all flags keep their values.
- R11: `up_en` and `dn_en` equal the level of `up_in` and `dn_in` sampled at the previous clock edge.
- R12: While `rst_n` is low, `acc` is 0, `ovf`, `unf`, `done`, `up_en` and `dn_en` are 0, and `empty` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| up_in | input | 1 | Count-up event level |
| dn_in | input | 1 | Count-down event level |
| clr | input | 1 | Zero the count and the sticky flags |
| load | input | 1 | Copy the preset into the count |
| preset | input | CNT_W (16) | Signed preset value |
| acc | output | CNT_W (16) | Signed count |
| done | output | 1 | Count at or above preset |
| ovf | output | 1 | Sticky overflow flag |
| unf | output | 1 | Sticky underflow flag |
| empty | output | 1 | Count equals zero |
| up_en | output | 1 | Sampled level of the up input |
| dn_en | output | 1 | Sampled level of the down input |

## Verification
Every ordered pair of previous and present (up, down) input levels is driven. This separates a real edge from a held level and checks that two edges at one clock edge cancel. Long holds and single-cycle pulse trains tell edge counting apart from level counting. Loads near each signed limit followed by short bursts exercise the wrap points, the sticky flags and the command priority. A long pseudo-random run then mixes edges, rare clears, loads and changing presets against an arithmetic model.

// File: rtl/evt_cnt_pkg.sv
package evt_cnt_pkg;

   typedef enum logic [2:0] {
      OP_HOLD  = 3'd0,
      OP_CLEAR = 3'd1,
      OP_LOAD  = 3'd2,
      OP_INC   = 3'd3,
      OP_DEC   = 3'd4
   } acc_op_e;

   // Priority: clear, then load, then a net edge direction.
   function automatic acc_op_e pick_op(input logic clr_i, input logic load_i,
                                       input logic inc_i, input logic dec_i);
      acc_op_e op;
      if (clr_i)               op = OP_CLEAR;
      else if (load_i)         op = OP_LOAD;
      else if (inc_i && !dec_i) op = OP_INC;
      else if (dec_i && !inc_i) op = OP_DEC;
      else                     op = OP_HOLD;
      return op;
   endfunction

endpackage

// File: rtl/evt_edge_detect.sv
module evt_edge_detect #(
   parameter int CH = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [CH-1:0] lvl,
   output logic [CH-1:0] rise,
   output logic [CH-1:0] held
);

   if (CH < 1) begin : g_bad_ch
      $error("evt_edge_detect: CH must be at least 1");
   end

   for (genvar i = 0; i < CH; i++) begin : g_ch
      logic q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q <= 1'b0;
         else        q <= lvl[i];
      end

      assign rise[i] = lvl[i] & ~q;
      assign held[i] = q;

      // R1: a detected edge cannot repeat on the next clock without a fall.
      a_r1_single_edge: assert property (@(posedge clk) disable iff (!rst_n)
         rise[i] |=> !rise[i]);
   end

endmodule

// File: rtl/evt_acc_core.sv
module evt_acc_core
   import evt_cnt_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    clr,
   input  logic                    load,
   input  logic                    inc,
   input  logic                    dec,
   input  logic signed [CNT_W-1:0] preset,
   output logic signed [CNT_W-1:0] acc_q,
   output logic signed [CNT_W-1:0] acc_next,
   output logic                    ovf_evt,
   output logic                    unf_evt
);

   localparam logic signed [CNT_W-1:0] MAX_V = {1'b0, {(CNT_W-1){1'b1}}};
   localparam logic signed [CNT_W-1:0] MIN_V = {1'b1, {(CNT_W-1){1'b0}}};
   localparam logic signed [CNT_W-1:0] ONE_V = {{(CNT_W-1){1'b0}}, 1'b1};

   if (CNT_W < 2) begin : g_bad_w
      $error("evt_acc_core: CNT_W must be at least 2");
   end

   acc_op_e op;

   always_comb begin
      op       = pick_op(clr, load, inc, dec);
      acc_next = acc_q;
      ovf_evt  = 1'b0;
      unf_evt  = 1'b0;
      case (op)
         OP_CLEAR: acc_next = '0;
         OP_LOAD:  acc_next = preset;
         OP_INC: begin
            // two's-complement add wraps naturally at the top
            acc_next = acc_q + ONE_V;
            ovf_evt  = (acc_q == MAX_V);
         end
         OP_DEC: begin
            acc_next = acc_q - ONE_V;
            unf_evt  = (acc_q == MIN_V);
         end
         default: acc_next = acc_q;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) acc_q <= '0;
      else        acc_q <= acc_next;
   end

   a_r8_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (acc_q == '0));

   a_r9_load_copy: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && load) |=> (acc_q == $past(preset)));

   a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !load && !inc && !dec) |=> $stable(acc_q));

   a_r3_cancel: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !load && inc && dec) |=> $stable(acc_q));

   a_r4_wrap_top: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !load && inc && !dec && acc_q == MAX_V) |=> (acc_q == MIN_V));

   a_r5_wrap_bottom: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !load && dec && !inc && acc_q == MIN_V) |=> (acc_q == MAX_V));

   a_r1_up_step: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !load && inc && !dec && acc_q != MAX_V) |=> (acc_q == $past(acc_q) + ONE_V));

   a_r2_down_step: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !load && dec && !inc && acc_q != MIN_V) |=> (acc_q == $past(acc_q) - ONE_V));

endmodule

// File: rtl/evt_status_flags.sv
module evt_status_flags #(
   parameter int CNT_W = 16
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    clr,
   input  logic signed [CNT_W-1:0] acc_next,
   input  logic signed [CNT_W-1:0] preset,
   input  logic                    ovf_evt,
   input  logic                    unf_evt,
   output logic                    done,
   output logic                    empty,
   output logic                    ovf,
   output logic                    unf
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done  <= 1'b0;
         empty <= 1'b1;
         ovf   <= 1'b0;
         unf   <= 1'b0;
      end else begin
         done  <= (acc_next >= preset);
         empty <= (acc_next == '0);
         if (clr) begin
            ovf <= 1'b0;
            unf <= 1'b0;
         end else begin
            if (ovf_evt) ovf <= 1'b1;
            if (unf_evt) unf <= 1'b1;
         end
      end
   end

   a_r4_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf && !clr) |=> ovf);

   a_r5_unf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (unf && !clr) |=> unf);

   a_r8_flags_clear: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (!ovf && !unf));

endmodule

// File: rtl/evt_updown_counter.sv
module evt_updown_counter #(
   parameter int CNT_W = 16
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    up_in,
   input  logic                    dn_in,
   input  logic                    clr,
   input  logic                    load,
   input  logic signed [CNT_W-1:0] preset,
   output logic signed [CNT_W-1:0] acc,
   output logic                    done,
   output logic                    ovf,
   output logic                    unf,
   output logic                    empty,
   output logic                    up_en,
   output logic                    dn_en
);

   localparam int CH     = 2;
   localparam int CH_UP  = 0;
   localparam int CH_DN  = 1;

   if (CNT_W < 2 || CNT_W > 64) begin : g_bad_w
      $error("evt_updown_counter: CNT_W out of range");
   end

   logic [CH-1:0] lvl, rise, held;
   logic signed [CNT_W-1:0] acc_next;
   logic ovf_evt, unf_evt;

   assign lvl[CH_UP] = up_in;
   assign lvl[CH_DN] = dn_in;

   evt_edge_detect #(.CH(CH)) u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .lvl   (lvl),
      .rise  (rise),
      .held  (held)
   );

   evt_acc_core #(.CNT_W(CNT_W)) u_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (clr),
      .load     (load),
      .inc      (rise[CH_UP]),
      .dec      (rise[CH_DN]),
      .preset   (preset),
      .acc_q    (acc),
      .acc_next (acc_next),
      .ovf_evt  (ovf_evt),
      .unf_evt  (unf_evt)
   );

   evt_status_flags #(.CNT_W(CNT_W)) u_flags (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (clr),
      .acc_next (acc_next),
      .preset   (preset),
      .ovf_evt  (ovf_evt),
      .unf_evt  (unf_evt),
      .done     (done),
      .empty    (empty),
      .ovf      (ovf),
      .unf      (unf)
   );

   assign up_en = held[CH_UP];
   assign dn_en = held[CH_DN];

   a_r7_empty_match: assert property (@(posedge clk) disable iff (!rst_n)
      empty == (acc == '0));

   a_r6_done_match: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (done == (acc >= $past(preset))));

   a_r11_up_mirror: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (up_en == $past(up_in)));

   a_r11_dn_mirror: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (dn_en == $past(dn_in)));

endmodule

// File: tb/evt_updown_counter_test.sv
module evt_updown_counter_test;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic up_i = 1'b0, dn_i = 1'b0, clr_i = 1'b0, ld_i = 1'b0;
   logic signed [15:0] pre_i = 16'sd0;
   logic signed [15:0] acc;
   logic done, ovf, unf, empty, up_en, dn_en;

   int checks = 0;
   int bad = 0;

   logic signed [15:0] m_acc = 16'sd0;
   bit m_ov, m_un, m_done, m_empty = 1'b1, m_pu, m_pd;

   always #2 clk = ~clk;

   evt_updown_counter #(.CNT_W(16)) uut (
      .clk(clk), .rst_n(rst_n), .up_in(up_i), .dn_in(dn_i), .clr(clr_i),
      .load(ld_i), .preset(pre_i), .acc(acc), .done(done), .ovf(ovf),
      .unf(unf), .empty(empty), .up_en(up_en), .dn_en(dn_en)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic compare(input string tag);
      chk(acc == m_acc, tag, "acc", int'(acc), int'(m_acc));
      chk(ovf == m_ov, "R4", "ovf", int'(ovf), int'(m_ov));
      chk(unf == m_un, "R5", "unf", int'(unf), int'(m_un));
      chk(done == m_done, "R6", "done", int'(done), int'(m_done));
      chk(empty == m_empty, "R7", "empty", int'(empty), int'(m_empty));
      chk(up_en == m_pu, "R11", "up_en", int'(up_en), int'(m_pu));
      chk(dn_en == m_pd, "R11", "dn_en", int'(dn_en), int'(m_pd));
   endtask

   // One clock: drive at negedge, model the edge, check at next negedge.
   task automatic cyc(input bit u, input bit d, input bit c, input bit l,
                      input string tag);
      bit ru, rd;
      up_i = u; dn_i = d; clr_i = c; ld_i = l;
      ru = u && !m_pu;
      rd = d && !m_pd;
      if (c) begin
         m_acc = 16'sd0; m_ov = 1'b0; m_un = 1'b0;
      end else if (l) begin
         m_acc = pre_i;
      end else if (ru && !rd) begin
         if (m_acc == 16'sh7fff) begin m_acc = 16'sh8000; m_ov = 1'b1; end
         else m_acc = m_acc + 16'sd1;
      end else if (rd && !ru) begin
         if (m_acc == 16'sh8000) begin m_acc = 16'sh7fff; m_un = 1'b1; end
         else m_acc = m_acc - 16'sd1;
      end
      m_pu = u; m_pd = d;
      m_done = (m_acc >= pre_i);
      m_empty = (m_acc == 16'sd0);
      @(posedge clk);
      @(negedge clk);
      compare(tag);
   endtask

   task automatic pulses(input bit up, input int n, input string tag);
      for (int k = 0; k < n; k++) begin
         cyc(up, !up, 1'b0, 1'b0, tag);
         cyc(1'b0, 1'b0, 1'b0, 1'b0, tag);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end

   initial begin
      logic [15:0] lfsr;
      repeat (3) @(negedge clk);
      // R12: reset state
      chk(acc == 16'sd0, "R12", "acc", int'(acc), 0);
      chk(!ovf && !unf, "R12", "ovf|unf", int'(ovf | unf), 0);
      chk(!done, "R12", "done", int'(done), 0);
      chk(empty, "R12", "empty", int'(empty), 1);
      chk(!up_en && !dn_en, "R12", "en", int'(up_en | dn_en), 0);
      rst_n = 1'b1;

      // R1: a held up level counts once
      pre_i = 16'sd5;
      for (int k = 0; k < 6; k++) cyc(1'b1, 1'b0, 1'b0, 1'b0, "R1");
      chk(acc == 16'sd1, "R1", "held count", int'(acc), 1);
      cyc(1'b0, 1'b0, 1'b0, 1'b0, "R1");
      // R6: done sets at preset and stays past it
      pulses(1'b1, 6, "R6");
      chk(acc == 16'sd7 && done, "R6", "acc past preset", int'(acc), 7);
      // R10: idle hold
      for (int k = 0; k < 5; k++) cyc(1'b0, 1'b0, 1'b0, 1'b0, "R10");
      chk(acc == 16'sd7, "R10", "retained", int'(acc), 7);

      // R3: every ordered pair of (up,dn) levels
      for (int p = 0; p < 4; p++)
         for (int c = 0; c < 4; c++) begin
            cyc(p[0], p[1], 1'b0, 1'b0, "R3");
            cyc(c[0], c[1], 1'b0, 1'b0, "R3");
         end
      cyc(1'b0, 1'b0, 1'b0, 1'b0, "R3");

      // R2: count down through zero into negatives
      cyc(1'b0, 1'b0, 1'b1, 1'b0, "R8");
      pulses(1'b0, 10, "R2");
      chk(acc == -16'sd10, "R2", "negative count", int'(acc), -10);

      // R4: overflow wrap and stickiness
      pre_i = 16'sd32765;
      cyc(1'b0, 1'b0, 1'b0, 1'b1, "R9");
      pulses(1'b1, 4, "R4");
      chk(acc == -16'sd32767 && ovf, "R4", "wrapped acc", int'(acc), -32767);
      pulses(1'b0, 2, "R4");
      chk(ovf, "R4", "ovf sticky", int'(ovf), 1);

      // R9: load beats an edge and keeps ovf
      pre_i = 16'sd100;
      cyc(1'b1, 1'b0, 1'b0, 1'b1, "R9");
      chk(acc == 16'sd100 && ovf, "R9", "load with edge", int'(acc), 100);
      cyc(1'b0, 1'b0, 1'b0, 1'b0, "R9");

      // R8: clear beats load and an edge, clears flags
      cyc(1'b1, 1'b0, 1'b1, 1'b1, "R8");
      chk(acc == 16'sd0 && !ovf, "R8", "clear priority", int'(acc), 0);
      cyc(1'b0, 1'b0, 1'b0, 1'b0, "R8");

      // R5: underflow wrap
      pre_i = -16'sd32767;
      cyc(1'b0, 1'b0, 1'b0, 1'b1, "R9");
      pulses(1'b0, 3, "R5");
      chk(acc == 16'sd32766 && unf, "R5", "wrapped acc", int'(acc), 32766);
      cyc(1'b0, 1'b0, 1'b1, 1'b0, "R8");
      chk(!unf, "R8", "unf cleared", int'(unf), 0);

      // Pseudo-random sweep against the model
      lfsr = 16'hACE1;
      for (int k = 0; k < 4000; k++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         if (lfsr[10:3] == 8'd7) pre_i = $signed(lfsr) >>> 8;
         cyc(lfsr[0], lfsr[1], lfsr[9:2] == 8'd0, lfsr[9:2] == 8'd1, "R1");
      end

      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end

endmodule